// File: doc/BRIEF.md
# Processor Trace Status Port Encoder

This block turns per-cycle execution events from a processor core into a real-time trace stream. It drives two 4-bit buses that an external analyser samples. The status nibble carries a code that is updated on every core clock cycle and does not depend on any external bus rate. The data nibble carries captured operand values, one nibble per cycle. Each operand burst is announced on the status nibble by a transfer code that gives the byte count.

The core supplies four level conditions: halted, stopped waiting for an interrupt, emulator-mode entry, and exception processing. It also supplies an instruction-class strobe with a 3-bit code, and an operand capture strobe with a 32-bit value and a byte count. Operand captures are queued in a small FIFO. When the FIFO is full, the block raises a stall request so that the core holds off further captures. A sample clock output lets the analyser take both buses on its rising edge, halfway through the cycle. One control input shuts the whole port off, and the port restarts cleanly once that input is released.

Top module: `trace_port_enc`

## Requirements
- R1: With no event pending and no burst able to start, the status bus shows 0 (continue) one cycle after the inputs are sampled.
- R2: An instruction strobe with class code k in 1..7, and no higher-priority event, makes the status bus show k on the next cycle. Code 2 and code 6 are reserved and are passed through unchanged.
- R3: When a queued operand starts its burst, the status bus shows 8+(N-1) for one cycle, where N is the byte count. The input op_bytes carries N-1, so 8 means 1 byte and 11 means 4 bytes.
- R4: Halted shows F, stopped shows E, emulator entry shows D and exception shows C. The code is shown on every cycle that the condition input is held, and the order among them is halted, then stopped, then emulator, then exception.
- R5: The data bus shows the operand least significant nibble first, one nibble per cycle, for 2N cycles. The first nibble appears on the cycle after the transfer code. At all other times the data bus shows 0. A following burst may announce itself during the last nibble, so back-to-back bursts leave no gap.
- R6: Operand captures go into a FIFO of DEPTH entries (4 by default). Stall is high exactly while the FIFO holds DEPTH entries. A capture offered while the FIFO is full is dropped.
- R7: The sample clock is the inverted core clock while tracing is enabled and stays low while it is disabled. Its rising edge therefore falls in the middle of each output cycle.
- R8: While trace_off is high, the status and data buses output 0 one cycle later, the FIFO and any burst in progress are discarded, captures are ignored, and stall is 0.
- R9: Synchronous reset drives the status bus, data bus, sample clock and stall to 0 and empties the FIFO.
- R10: A burst start outranks an instruction code, and that instruction code is then dropped. Any of the four conditions from R4 holds back a burst start until the condition clears, while a burst already in progress keeps streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| trace_off | input | 1 | Disables the trace port when high |
| evt_halt | input | 1 | Core halted (level) |
| evt_stop | input | 1 | Core stopped awaiting interrupt (level) |
| evt_emu | input | 1 | Emulator-mode entry in progress (level) |
| evt_exc | input | 1 | Exception processing in progress (level) |
| insn_valid | input | 1 | Instruction-class event strobe |
| insn_code | input | 3 | Instruction-class status code 1..7 |
| op_valid | input | 1 | Operand capture strobe |
| op_data | input | 32 | Captured operand value |
| op_bytes | input | 2 | Operand byte count minus one |
| pst | output | 4 | Registered status nibble |
| ddata | output | 4 | Registered operand data nibble |
| tclk | output | 1 | Trace sample clock |
| stall | output | 1 | FIFO full, core must hold captures |

## Verification
On every cycle the assertions check that a held halt or stop condition shows its code, that the disable input clears both buses, that the FIFO occupancy stays bounded and does not grow when the FIFO is full, and that a burst load sets the nibble count to twice the byte count. Only the bench scenarios can show the rest, because it depends on history and data. That covers the nibble order within a burst, gapless hand-over between consecutive bursts, bursts held back behind long halt periods, dropped captures while stall is high, and a clean restart after the port has been disabled in the middle of a burst.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int OP_W  = 32;
  localparam int NIB_W = 4;

  localparam logic [3:0] ST_CONT = 4'h0;
  localparam logic [3:0] ST_XFER = 4'h8;
  localparam logic [3:0] ST_EXC  = 4'hC;
  localparam logic [3:0] ST_EMU  = 4'hD;
  localparam logic [3:0] ST_STOP = 4'hE;
  localparam logic [3:0] ST_HALT = 4'hF;

  typedef struct packed {
    logic [1:0]      nbm1;
    logic [OP_W-1:0] data;
  } op_entry_t;

  localparam int ENTRY_W = $bits(op_entry_t);
endpackage

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full);
endmodule

// File: rtl/trace_nibble_shifter.sv
module trace_nibble_shifter #(
  parameter int OP_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            load,
  input  logic [OP_W-1:0] load_data,
  input  logic [1:0]      load_nbm1,
  output logic [3:0]      nib_q,
  output logic            free
);
  localparam int NIBS = OP_W / 4;
  localparam int CW   = $clog2(NIBS + 1);

  logic [OP_W-1:0] sh;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   load_cnt;

  assign free     = (cnt <= CW'(1));
  assign load_cnt = CW'({1'b0, load_nbm1} + 3'd1) << 1;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      sh    <= '0;
      cnt   <= '0;
      nib_q <= '0;
    end else begin
      if (cnt != '0) begin
        nib_q <= sh[3:0];
      end else begin
        nib_q <= '0;
      end
      if (load) begin
        sh  <= load_data;
        cnt <= load_cnt;
      end else if (cnt != '0) begin
        sh  <= sh >> 4;
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !flush) |=> (cnt == CW'(2) * (CW'($past(load_nbm1)) + CW'(1))));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == '0 && nib_q == 4'h0));
endmodule

// File: rtl/trace_status_pick.sv
module trace_status_pick (
  input  logic       halt,
  input  logic       stop,
  input  logic       emu,
  input  logic       exc,
  input  logic       xfer_ready,
  input  logic [1:0] xfer_nbm1,
  input  logic       insn_valid,
  input  logic [2:0] insn_code,
  output logic [3:0] code,
  output logic       launch
);
  import trace_pkg::*;

  always_comb begin
    launch = 1'b0;
    if (halt)             code = ST_HALT;
    else if (stop)        code = ST_STOP;
    else if (emu)         code = ST_EMU;
    else if (exc)         code = ST_EXC;
    else if (xfer_ready) begin
      code   = ST_XFER | {2'b00, xfer_nbm1};
      launch = 1'b1;
    end
    else if (insn_valid)  code = {1'b0, insn_code};
    else                  code = ST_CONT;
  end
endmodule

// File: rtl/trace_port_enc.sv
module trace_port_enc #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        trace_off,
  input  logic        evt_halt,
  input  logic        evt_stop,
  input  logic        evt_emu,
  input  logic        evt_exc,
  input  logic        insn_valid,
  input  logic [2:0]  insn_code,
  input  logic        op_valid,
  input  logic [31:0] op_data,
  input  logic [1:0]  op_bytes,
  output logic [3:0]  pst,
  output logic [3:0]  ddata,
  output logic        tclk,
  output logic        stall
);
  import trace_pkg::*;

  op_entry_t  wr_ent, rd_ent;
  logic       f_empty, f_full;
  logic       sh_free, launch;
  logic [3:0] code, pst_q, nib;
  logic       en_q;

  assign wr_ent = '{nbm1: op_bytes, data: op_data};

  trace_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .flush(trace_off),
    .push(op_valid && !trace_off), .wdata(wr_ent),
    .pop(launch), .rdata(rd_ent),
    .empty(f_empty), .full(f_full)
  );

  trace_status_pick pick_i (
    .halt(evt_halt), .stop(evt_stop), .emu(evt_emu), .exc(evt_exc),
    .xfer_ready(!f_empty && sh_free && !trace_off), .xfer_nbm1(rd_ent.nbm1),
    .insn_valid(insn_valid), .insn_code(insn_code),
    .code(code), .launch(launch)
  );

  trace_nibble_shifter #(.OP_W(OP_W)) shift_i (
    .clk(clk), .rst(rst), .flush(trace_off),
    .load(launch), .load_data(rd_ent.data), .load_nbm1(rd_ent.nbm1),
    .nib_q(nib), .free(sh_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pst_q <= ST_CONT;
      en_q  <= 1'b0;
    end else begin
      pst_q <= trace_off ? ST_CONT : code;
      en_q  <= !trace_off;
    end
  end

  assign pst   = pst_q;
  assign ddata = nib;
  assign stall = f_full;
  assign tclk  = en_q & ~clk;

  // R4
  halt_code_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_halt && !trace_off) |=> (pst == ST_HALT));

  // R4
  stop_code_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_stop && !evt_halt && !trace_off) |=> (pst == ST_STOP));

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    trace_off |=> (pst == 4'h0 && ddata == 4'h0 && !stall));
endmodule

// File: tb/trace_port_enc_tb_top.sv
`timescale 1ns/1ps
module trace_port_enc_tb_top;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trace_off = 1'b0;
  logic        evt_halt = 1'b0, evt_stop = 1'b0, evt_emu = 1'b0, evt_exc = 1'b0;
  logic        insn_valid = 1'b0;
  logic [2:0]  insn_code = 3'd0;
  logic        op_valid = 1'b0;
  logic [31:0] op_data = 32'd0;
  logic [1:0]  op_bytes = 2'd0;
  logic [3:0]  pst, ddata;
  logic        tclk, stall;

  always #2.5 clk = ~clk;

  trace_port_enc #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .trace_off(trace_off),
    .evt_halt(evt_halt), .evt_stop(evt_stop), .evt_emu(evt_emu), .evt_exc(evt_exc),
    .insn_valid(insn_valid), .insn_code(insn_code),
    .op_valid(op_valid), .op_data(op_data), .op_bytes(op_bytes),
    .pst(pst), .ddata(ddata), .tclk(tclk), .stall(stall)
  );

  typedef struct { logic [31:0] d; int nb; } op_t;
  op_t        mq[$];
  logic [3:0] nq[$];
  logic [3:0] e_pst = 0, e_dd = 0;
  logic       e_en = 0, e_stall = 0;
  string      pst_tag = "R9", dd_tag = "R9";
  int         vectors = 0, errors = 0;
  bit         done = 0;

  function automatic void model_step();
    bit hi, launch;
    op_t o;
    hi = evt_halt || evt_stop || evt_emu || evt_exc;
    if (trace_off) begin
      mq.delete(); nq.delete();
      e_pst = 0; e_dd = 0; e_en = 0; e_stall = 0;
      pst_tag = "R8"; dd_tag = "R8";
      return;
    end
    e_en = 1;
    launch = !hi && mq.size() > 0 && nq.size() <= 1;
    e_dd = (nq.size() > 0) ? nq.pop_front() : 4'h0;
    dd_tag = "R5";
    if (evt_halt)      e_pst = 4'hF;
    else if (evt_stop) e_pst = 4'hE;
    else if (evt_emu)  e_pst = 4'hD;
    else if (evt_exc)  e_pst = 4'hC;
    if (hi) pst_tag = (mq.size() > 0 || insn_valid) ? "R10" : "R4";
    else if (launch) begin
      o = mq.pop_front();
      e_pst = 4'(7 + o.nb);
      for (int i = 0; i < 2 * o.nb; i++) nq.push_back(4'((o.d >> (4 * i)) & 32'hF));
      pst_tag = insn_valid ? "R10" : "R3";
    end else if (insn_valid) begin
      e_pst = {1'b0, insn_code}; pst_tag = "R2";
    end else begin
      e_pst = 0; pst_tag = "R1";
    end
    if (op_valid && (mq.size() + (launch ? 1 : 0)) < DEPTH) begin
      o.d = op_data; o.nb = int'(op_bytes) + 1;
      mq.push_back(o);
    end
    e_stall = (mq.size() == DEPTH);
  endfunction

  task automatic compare();
    vectors++;
    if (pst !== e_pst) begin
      errors++; $display("FAIL %s pst actual %h expected %h at %0t", pst_tag, pst, e_pst, $time);
    end
    if (ddata !== e_dd) begin
      errors++; $display("FAIL %s ddata actual %h expected %h at %0t", dd_tag, ddata, e_dd, $time);
    end
    if (stall !== e_stall) begin
      errors++; $display("FAIL %s stall actual %b expected %b at %0t",
                         (pst_tag == "R9") ? "R9" : "R6", stall, e_stall, $time);
    end
    if (tclk !== e_en) begin
      errors++; $display("FAIL %s tclk actual %b expected %b at %0t",
                         (pst_tag == "R9") ? "R9" : "R7", tclk, e_en, $time);
    end
  endtask

  // inputs are already set at a falling edge; advance one cycle and compare
  task automatic cyc();
    model_step();
    @(negedge clk); #0.5;
    compare();
  endtask

  task automatic idle(input int n);
    evt_halt = 0; evt_stop = 0; evt_emu = 0; evt_exc = 0;
    insn_valid = 0; op_valid = 0;
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic put_op(input logic [31:0] d, input logic [1:0] b);
    op_valid = 1; op_data = d; op_bytes = b;
    cyc();
    op_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #0.5;
      compare();
    end
    rst = 0;
    pst_tag = "R1";
    // R1: idle
    idle(3);
    // R2: instruction class codes including reserved ones
    for (int k = 1; k < 8; k++) begin
      insn_valid = 1; insn_code = 3'(k); cyc();
    end
    idle(2);
    // R3 / R5: single bursts of 1 and 4 bytes
    put_op(32'h0000_00A5, 2'd0); idle(4);
    put_op(32'h8765_4321, 2'd3); idle(10);
    // R5: back-to-back bursts with no gap
    put_op(32'h0000_1234, 2'd1);
    put_op(32'h00AB_CDEF, 2'd2);
    put_op(32'h0000_005A, 2'd0);
    idle(18);
    // R4 / R10: multi-cycle halt with a pending burst, then each condition
    put_op(32'hDEAD_BEEF, 2'd3);
    evt_halt = 1; evt_stop = 1; evt_emu = 1; evt_exc = 1; insn_valid = 1;
    for (int i = 0; i < 6; i++) cyc();
    evt_halt = 0; cyc(); cyc();
    evt_stop = 0; cyc(); cyc();
    evt_emu = 0; cyc(); cyc();
    evt_exc = 0; cyc();
    idle(10);
    // R10: burst start beats instruction code
    put_op(32'h0000_0077, 2'd0);
    insn_valid = 1; insn_code = 3'd5; cyc(); cyc();
    idle(4);
    // R6: fill the FIFO, keep offering while stall is high
    for (int i = 0; i < 9; i++) begin
      op_valid = 1; op_data = 32'h1111_1111 * (i + 1); op_bytes = 2'd3; cyc();
    end
    op_valid = 0;
    idle(80);
    // R8: disable mid-burst with activity, then re-enable
    put_op(32'hCAFE_F00D, 2'd3);
    put_op(32'h1357_9BDF, 2'd3);
    idle(3);
    trace_off = 1; evt_halt = 1; op_valid = 1; op_data = 32'h42; insn_valid = 1;
    for (int i = 0; i < 4; i++) cyc();
    trace_off = 0; evt_halt = 0; op_valid = 0; insn_valid = 0;
    idle(4);
    put_op(32'h0000_00C3, 2'd0); idle(4);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      evt_halt = (r < 8);
      evt_stop = (r[6:0] < 10);
      evt_emu  = (r[5:0] == 3);
      evt_exc  = (r[4:0] == 7);
      insn_valid = ($urandom_range(0, 2) == 0);
      insn_code  = 3'($urandom_range(1, 7));
      op_valid   = ($urandom_range(0, 3) == 0) && (!stall || $urandom_range(0, 4) == 0);
      op_data    = $urandom;
      op_bytes   = 2'($urandom);
      trace_off  = ($urandom_range(0, 150) == 0);
      cyc();
    end
    trace_off = 0;
    idle(30);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule